// File: doc/BRIEF.md
# Digital Potentiometer Wiper Controller

This block is the digital control core of a 64-tap digital potentiometer. It holds a 6-bit volatile wiper register. The wiper value is decoded into a one-hot select across 64 tap switches. The block also holds a bank of four 6-bit data registers that stand in for nonvolatile storage. A host drives a parallel command port with an opcode, a register index, a data word, a direction bit and a valid/ready handshake. Through this port the host can load the wiper, step it, move values between the wiper and the data registers, and read or write those registers.

Writes to the storage registers model a slow nonvolatile cycle. After such a write, the block stays busy for a fixed, parameterized number of clocks and accepts no commands in that time. After every reset, the wiper is restored from data register 0 in one dedicated cycle. A cold reset returns the data registers to a configured value. A warm reset leaves them unchanged.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set, at index `wiper_o`. Wiper 0 selects bit 0 (the low-terminal tap) and wiper 63 selects bit 63 (the high-terminal tap).
- R2: Reset behaviour:
  - For the first cycle after `rst_ni` rises, `cmd_ready_o` is low. After that edge, `wiper_o` equals data register 0.
  - A reset with `warm_rst_i` low loads every data register with `COLD_VAL`.
  - A reset with `warm_rst_i` high leaves the data registers unchanged.
- R3: Opcode 0 (write wiper) loads `cmd_data_i` into the wiper. The new value is visible in the cycle after acceptance.
- R4: Opcode 1 (transfer) loads data register `cmd_idx_i` into the wiper.
- R5: Opcode 5 (step) changes the wiper by one position:
  - With `cmd_up_i`=1 it adds one, saturating at 63.
  - With `cmd_up_i`=0 it subtracts one, saturating at 0.
- R6: Opcode 4 (write register) stores `cmd_data_i` into data register `cmd_idx_i`. Opcode 2 (store) copies the wiper into data register `cmd_idx_i`.
- R7: Read commands and the read port:
  - Opcode 3 returns data register `cmd_idx_i` on `rd_data_o`.
  - Opcode 6 returns the wiper on `rd_data_o`.
  - For both, `rd_valid_o` is high for exactly the one cycle after acceptance.
- R8: Storage-write timing and the busy window:
  - After opcode 2 or 4 is accepted, `busy_o` is high and `cmd_ready_o` is low for exactly `BUSY_CYCLES` cycles.
  - A command presented while `cmd_ready_o` is low has no effect.
- R9: Opcode 7 is accepted but changes no state, starts no busy period and produces no read pulse.
- R10: `rd_valid_o` is high only in the cycle right after a read command (opcode 3 or 6) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| warm_rst_i | input | 1 | High during reset keeps the data registers |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted when high together with valid |
| cmd_op_i | input | 3 | Opcode |
| cmd_idx_i | input | 2 | Data register index |
| cmd_data_i | input | 6 | Write data |
| cmd_up_i | input | 1 | Step direction, 1 = up |
| wiper_o | output | 6 | Current wiper value |
| tap_sel_o | output | 64 | One-hot tap select |
| rd_data_o | output | 6 | Read result |
| rd_valid_o | output | 1 | Read result valid pulse |
| busy_o | output | 1 | Storage write in progress |

## Verification
The assertions check the following on every cycle:
- the tap select is one-hot at the wiper index;
- ready and busy are never high together;
- the wiper holds steady through a busy window;
- upward steps saturate at the top;
- every storage write is followed by busy;
- a read pulse always traces back to an accepted read.

Some behaviours need the scenarios in the bench:
- the exact length of the busy window;
- restore from register 0 under cold and warm resets;
- register contents after stores and transfers;
- commands dropped while busy;
- the effect of the reserved opcode.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [2:0] {
    OP_WR_WIPER = 3'd0,
    OP_XFR      = 3'd1,
    OP_STORE    = 3'd2,
    OP_RD_DR    = 3'd3,
    OP_WR_DR    = 3'd4,
    OP_STEP     = 3'd5,
    OP_RD_WIPER = 3'd6,
    OP_RSVD     = 3'd7
  } pot_op_e;

  typedef enum logic [1:0] {
    ST_RESTORE = 2'd0,
    ST_IDLE    = 2'd1,
    ST_BUSY    = 2'd2
  } pot_state_e;
endpackage

// File: rtl/pot_cmd_fsm.sv
module pot_cmd_fsm
  import pot_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 500_000,
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_valid_i,
  input  pot_op_e cmd_op_i,
  output logic    ready_o,
  output logic    busy_o,
  output logic    restore_o,
  output logic    accept_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

  pot_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic nv_write;

  assign ready_o   = (state_q == ST_IDLE);
  assign busy_o    = (state_q == ST_BUSY);
  assign restore_o = (state_q == ST_RESTORE);
  assign accept_o  = cmd_valid_i && ready_o;
  assign nv_write  = (cmd_op_i == OP_STORE) || (cmd_op_i == OP_WR_DR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESTORE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RESTORE: state_q <= ST_IDLE;
        ST_IDLE: begin
          if (accept_o && nv_write) begin
            state_q <= ST_BUSY;
            cnt_q   <= LOAD_VAL;
          end
        end
        ST_BUSY: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pot_reg_bank.sv
module pot_reg_bank #(
  parameter int unsigned W        = 6,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [W-1:0] COLD_VAL = '0,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o,
  output logic [W-1:0]     dr0_o
);
  logic [W-1:0] dr_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // warm reset leaves stored contents untouched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        if (!warm_rst_i) dr_q[g] <= COLD_VAL;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        dr_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = dr_q[rd_idx_i];
  assign dr0_o     = dr_q[0];
endmodule

// File: rtl/pot_wiper.sv
module pot_wiper #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restore_i,
  input  logic [W-1:0] restore_val_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         up_i,
  output logic [W-1:0] wiper_o
);
  localparam logic [W-1:0] MAX_POS = '1;

  logic [W-1:0] wiper_q, wiper_d;

  always_comb begin
    wiper_d = wiper_q;
    if (restore_i) begin
      wiper_d = restore_val_i;
    end else if (load_i) begin
      wiper_d = load_val_i;
    end else if (step_i) begin
      if (up_i && wiper_q != MAX_POS)   wiper_d = wiper_q + 1'b1;
      else if (!up_i && wiper_q != '0)  wiper_d = wiper_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wiper_q <= '0;
    else         wiper_q <= wiper_d;
  end

  assign wiper_o = wiper_q;
endmodule

// File: rtl/pot_tap_decode.sv
module pot_tap_decode #(
  parameter int unsigned W = 6,
  localparam int unsigned TAPS = 1 << W
) (
  input  logic [W-1:0]    wiper_i,
  output logic [TAPS-1:0] tap_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_o[t] = (wiper_i == W'(t));
  end
endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
  import pot_pkg::*;
#(
  parameter int unsigned W           = 6,
  parameter int unsigned NUM_REGS    = 4,
  parameter int unsigned BUSY_CYCLES = 500_000,
  parameter logic [W-1:0] COLD_VAL   = 6'h20,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned TAPS       = 1 << W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_op_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [W-1:0]     cmd_data_i,
  input  logic             cmd_up_i,
  output logic [W-1:0]     wiper_o,
  output logic [TAPS-1:0]  tap_sel_o,
  output logic [W-1:0]     rd_data_o,
  output logic             rd_valid_o,
  output logic             busy_o
);
  pot_op_e op;
  logic accept, restore;
  logic [W-1:0] dr_rd, dr0, wiper;
  logic dr_wr_en, wp_load, wp_step;
  logic [W-1:0] dr_wr_data, wp_load_val;
  logic [W-1:0] rd_data_q;
  logic rd_valid_q;

  assign op = pot_op_e'(cmd_op_i);

  pot_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
    .clk_i, .rst_ni,
    .cmd_valid_i,
    .cmd_op_i  (op),
    .ready_o   (cmd_ready_o),
    .busy_o,
    .restore_o (restore),
    .accept_o  (accept)
  );

  assign dr_wr_en   = accept && (op == OP_WR_DR || op == OP_STORE);
  assign dr_wr_data = (op == OP_STORE) ? wiper : cmd_data_i;

  pot_reg_bank #(.W(W), .NUM_REGS(NUM_REGS), .COLD_VAL(COLD_VAL)) u_bank (
    .clk_i, .rst_ni, .warm_rst_i,
    .wr_en_i   (dr_wr_en),
    .wr_idx_i  (cmd_idx_i),
    .wr_data_i (dr_wr_data),
    .rd_idx_i  (cmd_idx_i),
    .rd_data_o (dr_rd),
    .dr0_o     (dr0)
  );

  assign wp_load     = accept && (op == OP_WR_WIPER || op == OP_XFR);
  assign wp_load_val = (op == OP_XFR) ? dr_rd : cmd_data_i;
  assign wp_step     = accept && (op == OP_STEP);

  pot_wiper #(.W(W)) u_wiper (
    .clk_i, .rst_ni,
    .restore_i     (restore),
    .restore_val_i (dr0),
    .load_i        (wp_load),
    .load_val_i    (wp_load_val),
    .step_i        (wp_step),
    .up_i          (cmd_up_i),
    .wiper_o       (wiper)
  );

  pot_tap_decode #(.W(W)) u_dec (
    .wiper_i (wiper),
    .tap_o   (tap_sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= accept && (op == OP_RD_DR || op == OP_RD_WIPER);
      if (accept && op == OP_RD_DR)    rd_data_q <= dr_rd;
      if (accept && op == OP_RD_WIPER) rd_data_q <= wiper;
    end
  end

  assign wiper_o    = wiper;
  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/pot_wiper_ctrl_chk.sv
module pot_wiper_ctrl_chk #(
  parameter int unsigned W     = 6,
  parameter int unsigned IDX_W = 2,
  localparam int unsigned TAPS = 1 << W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             warm_rst_i,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [2:0]       cmd_op_i,
  input logic [IDX_W-1:0] cmd_idx_i,
  input logic [W-1:0]     cmd_data_i,
  input logic             cmd_up_i,
  input logic [W-1:0]     wiper_o,
  input logic [TAPS-1:0]  tap_sel_o,
  input logic [W-1:0]     rd_data_o,
  input logic             rd_valid_o,
  input logic             busy_o
);
  localparam logic [W-1:0] TOP = '1;
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  // R1
  tap_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(tap_sel_o) == 1) && tap_sel_o[wiper_o]);

  // R8
  ready_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ready_o && busy_o));

  // R8
  nv_write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_op_i == 3'd2 || cmd_op_i == 3'd4)) |=> busy_o);

  // R8
  busy_hold_wiper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !acc) |=> $stable(wiper_o));

  // R5
  step_sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd5 && cmd_up_i && wiper_o == TOP) |=> (wiper_o == TOP));

  // R10
  rd_valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_op_i == 3'd3 || cmd_op_i == 3'd6)) |=> rd_valid_o);

  // R10
  rd_valid_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(acc && (cmd_op_i == 3'd3 || cmd_op_i == 3'd6))) |=> !rd_valid_o);
endmodule

bind pot_wiper_ctrl pot_wiper_ctrl_chk #(.W(W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/pot_wiper_ctrl_tb.sv
module pot_wiper_ctrl_tb_top;
  localparam int W = 6;
  localparam int BUSY = 5;
  localparam logic [5:0] COLD = 6'h15;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic warm_rst_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [2:0] cmd_op_i = '0;
  logic [1:0] cmd_idx_i = '0;
  logic [5:0] cmd_data_i = '0;
  logic cmd_up_i = 1'b0;
  logic [5:0] wiper_o;
  logic [63:0] tap_sel_o;
  logic [5:0] rd_data_o;
  logic rd_valid_o;
  logic busy_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  pot_wiper_ctrl #(.BUSY_CYCLES(BUSY), .COLD_VAL(COLD)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] idx,
                       input logic [5:0] d, input logic up);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_op_i = op; cmd_idx_i = idx; cmd_data_i = d; cmd_up_i = up;
    cmd_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o) begin
      if (cmd_ready_o) n = 1000;
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset(input logic warm);
    @(negedge clk_i);
    warm_rst_i = warm; rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 restore cycle
    check(cmd_ready_o == 1'b0, "R2", cmd_ready_o, 0);
    @(negedge clk_i);
    warm_rst_i = 1'b0;
  endtask

  task automatic read_dr(input logic [1:0] idx, input int exp, input string req);
    issue(3'd3, idx, '0, 1'b0);
    check(rd_valid_o && rd_data_o == exp, req, rd_data_o, exp);
    @(negedge clk_i);
    // R7 single-cycle pulse
    check(rd_valid_o == 1'b0, "R7", rd_valid_o, 0);
  endtask

  function automatic int dr_pat(input int i);
    return (i * 13 + 7) % 64;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    int exp;
    do_reset(1'b0);
    check(wiper_o == COLD && cmd_ready_o, "R2", wiper_o, COLD);
    check(rd_valid_o == 1'b0 && busy_o == 1'b0, "R10", rd_valid_o, 0);

    // R3 / R1 sweep every wiper value
    for (int v = 0; v < 64; v++) begin
      issue(3'd0, '0, 6'(v), 1'b0);
      check(wiper_o == v, "R3", wiper_o, v);
      check(tap_sel_o == (64'd1 << v), "R1", $clog2(tap_sel_o), v);
    end

    // R6 / R8 write every data register, measure busy
    for (int i = 0; i < 4; i++) begin
      issue(3'd4, 2'(i), 6'(dr_pat(i)), 1'b0);
      busy_len(n);
      check(n == BUSY, "R8", n, BUSY);
    end
    for (int i = 0; i < 4; i++) read_dr(2'(i), dr_pat(i), "R6");

    // R4 transfer each register
    for (int i = 0; i < 4; i++) begin
      issue(3'd1, 2'(i), 6'h3F, 1'b0);
      check(wiper_o == dr_pat(i), "R4", wiper_o, dr_pat(i));
    end

    // R5 saturating steps
    issue(3'd0, '0, 6'd60, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      issue(3'd5, '0, '0, 1'b1);
      exp = (60 + k > 63) ? 63 : 60 + k;
      check(wiper_o == exp, "R5", wiper_o, exp);
    end
    issue(3'd0, '0, 6'd3, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      issue(3'd5, '0, '0, 1'b0);
      exp = (3 - k < 0) ? 0 : 3 - k;
      check(wiper_o == exp, "R5", wiper_o, exp);
    end

    // R6 store wiper
    issue(3'd0, '0, 6'h2A, 1'b0);
    issue(3'd2, 2'd2, '0, 1'b0);
    busy_len(n);
    check(n == BUSY, "R8", n, BUSY);
    read_dr(2'd2, 6'h2A, "R6");

    // R7 read wiper
    issue(3'd6, '0, '0, 1'b0);
    check(rd_valid_o && rd_data_o == 6'h2A, "R7", rd_data_o, 6'h2A);

    // R8 command while busy is dropped
    issue(3'd4, 2'd1, 6'h11, 1'b0);
    cmd_op_i = 3'd0; cmd_data_i = 6'h01; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    busy_len(n);
    check(wiper_o == 6'h2A, "R8", wiper_o, 6'h2A);

    // R9 reserved opcode
    issue(3'd7, 2'd1, 6'h05, 1'b1);
    check(wiper_o == 6'h2A && !busy_o && !rd_valid_o && cmd_ready_o, "R9", wiper_o, 6'h2A);
    read_dr(2'd1, 6'h11, "R9");

    // R2 warm reset keeps data registers
    do_reset(1'b1);
    check(wiper_o == dr_pat(0), "R2", wiper_o, dr_pat(0));
    read_dr(2'd3, dr_pat(3), "R2");

    // R2 cold reset reloads
    do_reset(1'b0);
    check(wiper_o == COLD, "R2", wiper_o, COLD);
    read_dr(2'd1, COLD, "R2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule